// File: doc/BRIEF.md
# Automatic Sync Source Selector

This block decides where a display's vertical and horizontal drive pulses come from. Three sources may be offered at once: a pair of separate horizontal and vertical sync streams, a composite sync stream, or sync stripped from the video signal. Every stream arrives already sliced to a single bit with active-high polarity. Each external source comes with a presence flag. From these flags the block picks a source by a fixed priority. It derives a vertical pulse from composite or video sync by measuring how long each sync pulse stays high, and then drives registered VD and HD outputs.

Two further outputs support the rest of the display pipeline. A status flag tells external sync apart from video-derived sync. A vertical-interval indicator marks the cycles in which VD is active. An HD-keep control decides whether HD pulses continue through the vertical interval or are blanked there. A change of source never takes effect in the middle of a pulse. The block waits until the newly requested source begins a VD pulse while the current VD output is low.

Everything runs on one sample clock, 100 MHz by default. The width threshold for the vertical separator is given in nanoseconds and converted to clock cycles at elaboration.

Top module: `sync_source_select`

## Requirements
- R1: When both presence flags are high, VD follows the vertical separate stream and HD follows the composite/horizontal stream, each two clock edges after the input is sampled.
- R2: When only the composite presence flag is high, HD follows the composite stream and VD is the vertical pulse separated from that same stream.
- R3: When the composite presence flag is low (whatever the vertical flag says), VD is the pulse separated from the video sync stream and HD follows the video sync stream.
- R4: The separated vertical pulse goes high at the sample in which the stream has been high for THRESH consecutive samples, where THRESH = CLK_MHZ*SEP_NS/1000 (400 by default). It stays high until the first low sample. A run shorter than THRESH never produces it.
- R5: While hd_keep was low at sampling and the selected VD is high, HD is forced low. While hd_keep is high, HD passes unchanged through the vertical interval.
- R6: ext_sync is high exactly when at least one presence flag was high two edges earlier.
- R7: When the requested source differs from the active one, the switch happens only in the cycle where the requested source's VD candidate rises while the VD output is low. Until then the old source keeps driving both outputs.
- R8: During and right after reset, all outputs are low and the video source is active.
- R9: vint_out is high in exactly the cycles in which vd_out is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| vsep_present | input | 1 | Vertical separate sync is present |
| csync_present | input | 1 | Composite or horizontal sync is present |
| vsep_sync | input | 1 | Vertical separate sync stream, active high |
| csync_sync | input | 1 | Composite/horizontal sync stream, active high |
| vid_sync | input | 1 | Sync stripped from video, active high |
| hd_keep | input | 1 | 1: HD passes during the vertical interval; 0: HD is blanked there |
| vd_out | output | 1 | Vertical drive output |
| hd_out | output | 1 | Horizontal drive output |
| ext_sync | output | 1 | 1 when any external sync is present |
| vint_out | output | 1 | Vertical interval indicator |

## Verification
The assertions assume that every input is synchronous to the sample clock and that THRESH is at least two. They also assume that presence flags and hd_keep take effect through the same two-register path as the streams, so their timing checks look exactly two edges back and start only once two edges have passed since reset. The bench changes every input on the falling edge only. It keeps sync runs well apart from the threshold, except where R4's boundary is probed on purpose with runs of THRESH-1 and THRESH samples. It raises presence flags only while the streams are idle, so that every source switch happens on a clean pulse edge.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;
  localparam int NSRC = 3;
  typedef enum logic [1:0] {
    SRC_SEP  = 2'd0,
    SRC_COMP = 2'd1,
    SRC_VID  = 2'd2
  } src_e;
endpackage

// File: rtl/sync_vsep.sv
// Width-measuring vertical separator: the output rises once a run reaches TH_CYC samples.
module sync_vsep #(
  parameter int TH_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic vpulse_o
);
  localparam int CW = $clog2(TH_CYC + 1);
  localparam logic [CW-1:0] TH_MAX = CW'(TH_CYC);
  localparam logic [CW-1:0] TH_M1  = CW'(TH_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      vpulse_o <= 1'b0;
    end else if (sync_i) begin
      if (run_q != TH_MAX) run_q <= run_q + 1'b1;
      vpulse_o <= (run_q >= TH_M1);
    end else begin
      run_q    <= '0;
      vpulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_front.sv
// Stage A: registers the streams and flags; generates one separator per derived source.
module sync_front
  import sync_sel_pkg::*;
#(
  parameter int TH_CYC = 400
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vsep_present,
  input  logic            csync_present,
  input  logic            vsep_sync,
  input  logic            csync_sync,
  input  logic            vid_sync,
  input  logic            hd_keep,
  output logic [NSRC-1:0] cand_vd,
  output logic [NSRC-1:0] cand_hd,
  output logic            vsp_q,
  output logic            csp_q,
  output logic            keep_q
);
  localparam int NDER = 2;

  logic [NDER-1:0] der_in;
  logic [NDER-1:0] der_vp;
  logic            vs_q, cs_q, vid_q;

  assign der_in = {vid_sync, csync_sync};

  for (genvar g = 0; g < NDER; g++) begin : g_sep
    sync_vsep #(.TH_CYC(TH_CYC)) u_sep (
      .clk     (clk),
      .rst     (rst),
      .sync_i  (der_in[g]),
      .vpulse_o(der_vp[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q   <= 1'b0;
      cs_q   <= 1'b0;
      vid_q  <= 1'b0;
      vsp_q  <= 1'b0;
      csp_q  <= 1'b0;
      keep_q <= 1'b1;
    end else begin
      vs_q   <= vsep_sync;
      cs_q   <= csync_sync;
      vid_q  <= vid_sync;
      vsp_q  <= vsep_present;
      csp_q  <= csync_present;
      keep_q <= hd_keep;
    end
  end

  always_comb begin
    cand_vd           = '0;
    cand_hd           = '0;
    cand_vd[SRC_SEP]  = vs_q;
    cand_hd[SRC_SEP]  = cs_q;
    cand_vd[SRC_COMP] = der_vp[0];
    cand_hd[SRC_COMP] = cs_q;
    cand_vd[SRC_VID]  = der_vp[1];
    cand_hd[SRC_VID]  = vid_q;
  end
endmodule

// File: rtl/sync_src_pick.sv
// Stage B: priority request, frame-aligned switch, HD gating, registered outputs.
module sync_src_pick
  import sync_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] cand_vd,
  input  logic [NSRC-1:0] cand_hd,
  input  logic            vsp_q,
  input  logic            csp_q,
  input  logic            keep_q,
  output logic            vd_out,
  output logic            hd_out,
  output logic            ext_sync,
  output logic            vint_out,
  output src_e            cur_o
);
  src_e            req, cur_q, cur_nxt;
  logic [NSRC-1:0] prev_q;
  logic            vd_nxt, hd_nxt;

  always_comb begin
    if (vsp_q && csp_q) req = SRC_SEP;
    else if (csp_q)     req = SRC_COMP;
    else                req = SRC_VID;
  end

  always_comb begin
    cur_nxt = cur_q;
    if ((req != cur_q) && cand_vd[req] && !prev_q[req] && !vd_out)
      cur_nxt = req;
  end

  always_comb begin
    vd_nxt = cand_vd[cur_nxt];
    hd_nxt = cand_hd[cur_nxt] & ~(vd_nxt & ~keep_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= SRC_VID;
      prev_q   <= '0;
      vd_out   <= 1'b0;
      hd_out   <= 1'b0;
      vint_out <= 1'b0;
      ext_sync <= 1'b0;
    end else begin
      cur_q    <= cur_nxt;
      prev_q   <= cand_vd;
      vd_out   <= vd_nxt;
      hd_out   <= hd_nxt;
      vint_out <= vd_nxt;
      ext_sync <= vsp_q | csp_q;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/sync_source_select.sv
module sync_source_select
  import sync_sel_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int SEP_NS  = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic vsep_present,
  input  logic csync_present,
  input  logic vsep_sync,
  input  logic csync_sync,
  input  logic vid_sync,
  input  logic hd_keep,
  output logic vd_out,
  output logic hd_out,
  output logic ext_sync,
  output logic vint_out
);
  localparam int TH_CYC = CLK_MHZ * SEP_NS / 1000;

  logic [NSRC-1:0] cand_vd, cand_hd;
  logic            vsp_q, csp_q, keep_q;
  src_e            cur_src;

  sync_front #(.TH_CYC(TH_CYC)) u_front (
    .clk          (clk),
    .rst          (rst),
    .vsep_present (vsep_present),
    .csync_present(csync_present),
    .vsep_sync    (vsep_sync),
    .csync_sync   (csync_sync),
    .vid_sync     (vid_sync),
    .hd_keep      (hd_keep),
    .cand_vd      (cand_vd),
    .cand_hd      (cand_hd),
    .vsp_q        (vsp_q),
    .csp_q        (csp_q),
    .keep_q       (keep_q)
  );

  sync_src_pick u_pick (
    .clk     (clk),
    .rst     (rst),
    .cand_vd (cand_vd),
    .cand_hd (cand_hd),
    .vsp_q   (vsp_q),
    .csp_q   (csp_q),
    .keep_q  (keep_q),
    .vd_out  (vd_out),
    .hd_out  (hd_out),
    .ext_sync(ext_sync),
    .vint_out(vint_out),
    .cur_o   (cur_src)
  );
endmodule

// File: rtl/sync_source_select_chk.sv
module sync_source_select_chk (
  input logic       clk,
  input logic       rst,
  input logic       vsep_present,
  input logic       csync_present,
  input logic       csync_sync,
  input logic       hd_keep,
  input logic       vd_out,
  input logic       hd_out,
  input logic       ext_sync,
  input logic       vint_out,
  input logic [1:0] cur
);
  logic [1:0] warm_q;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end
  assign warm = (warm_q == 2'd2);

  // R8: outputs are low in the cycle after a reset edge
  p_reset_clear_r8: assert property (@(posedge clk)
    $past(rst) |-> (!vd_out && !hd_out && !ext_sync && !vint_out));

  // R6: the status flag tracks presence with two edges of latency
  p_ext_flag_r6: assert property (@(posedge clk) disable iff (rst)
    warm |-> (ext_sync == $past(vsep_present | csync_present, 2)));

  // R5: blanking of HD inside the vertical interval
  p_hd_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(hd_keep, 2) && vd_out) |-> !hd_out);

  // R7: a source change coincides with a fresh VD rising edge
  p_switch_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (warm && (cur != $past(cur))) |-> (vd_out && !$past(vd_out)));

  // R4: composite-derived VD drops as soon as the stream goes low
  p_sep_release_r4: assert property (@(posedge clk) disable iff (rst)
    (warm && (cur == 2'd1) && !$past(csync_sync, 2)) |-> !vd_out);

  // R9: interval indicator and VD agree
  p_vint_match_r9: assert property (@(posedge clk) disable iff (rst)
    vint_out == vd_out);
endmodule

bind sync_source_select sync_source_select_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .vsep_present (vsep_present),
  .csync_present(csync_present),
  .csync_sync   (csync_sync),
  .hd_keep      (hd_keep),
  .vd_out       (vd_out),
  .hd_out       (hd_out),
  .ext_sync     (ext_sync),
  .vint_out     (vint_out),
  .cur          (cur_src)
);

// File: tb/sync_source_select_bench.sv
`timescale 1ns/1ps
module sync_source_select_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 400;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsp = 1'b0, csp = 1'b0, keep = 1'b1;
  logic [2:0] strm = 3'b000;   // bit0 vertical separate, bit1 composite, bit2 video
  logic vd_out, hd_out, ext_sync, vint_out;

  int total = 0;
  int bad = 0;
  int vd_win = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_source_select u_sync_source_select (
    .clk(clk), .rst(rst),
    .vsep_present(vsp), .csync_present(csp),
    .vsep_sync(strm[0]), .csync_sync(strm[1]), .vid_sync(strm[2]),
    .hd_keep(keep),
    .vd_out(vd_out), .hd_out(hd_out), .ext_sync(ext_sync), .vint_out(vint_out)
  );

  // Behavioural reference: run lengths, two-edge latency, pending source switch.
  int run_c, run_v, m_cur;
  bit a_vs, a_cs, a_vid, a_vsp, a_csp, a_keep, a_sc, a_sv;
  bit m_prev [3];
  bit m_vd, m_hd, m_ext, m_vint;

  always @(posedge clk) begin
    bit cvd [3];
    bit chd [3];
    int req;
    if (rst) begin
      run_c = 0; run_v = 0; m_cur = 2;
      a_vs = 0; a_cs = 0; a_vid = 0; a_vsp = 0; a_csp = 0; a_keep = 1; a_sc = 0; a_sv = 0;
      for (int i = 0; i < 3; i++) m_prev[i] = 0;
      m_vd = 0; m_hd = 0; m_ext = 0; m_vint = 0;
    end else begin
      cvd[0] = a_vs; cvd[1] = a_sc; cvd[2] = a_sv;
      chd[0] = a_cs; chd[1] = a_cs; chd[2] = a_vid;
      req = (a_vsp && a_csp) ? 0 : (a_csp ? 1 : 2);
      if (req != m_cur && cvd[req] && !m_prev[req] && !m_vd) m_cur = req;
      for (int i = 0; i < 3; i++) m_prev[i] = cvd[i];
      m_vd = cvd[m_cur];
      m_hd = chd[m_cur] && !(m_vd && !a_keep);
      m_vint = m_vd;
      m_ext = a_vsp || a_csp;
      run_c = strm[1] ? run_c + 1 : 0;
      run_v = strm[2] ? run_v + 1 : 0;
      a_sc = (run_c >= TH);
      a_sv = (run_v >= TH);
      a_vs = strm[0]; a_cs = strm[1]; a_vid = strm[2];
      a_vsp = vsp; a_csp = csp; a_keep = keep;
    end
  end

  function automatic string src_tag(int s);
    return (s == 0) ? "R1" : ((s == 1) ? "R2/R4" : "R3");
  endfunction

  task automatic check(bit act, bit exp, string tag, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(vd_out, m_vd, src_tag(m_cur), "vd_out");
      check(hd_out, m_hd, (m_vd && !a_keep) ? "R5" : src_tag(m_cur), "hd_out");
      check(ext_sync, m_ext, "R6", "ext_sync");
      check(vint_out, m_vint, "R9", "vint_out");
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vd_out) vd_win++;
    end
  endtask

  task automatic pulse(logic [2:0] mask, int hi, int lo);
    strm = mask;
    tick(hi);
    strm = 3'b000;
    tick(lo);
  endtask

  task automatic count_check(int exp, string tag);
    total++;
    if (vd_win != exp) begin
      bad++;
      $display("FAIL %s vd high cycles: actual=%0d expected=%0d", tag, vd_win, exp);
    end
    vd_win = 0;
  endtask

  task automatic frame(logic [2:0] hmask, logic [2:0] vmask, int vlen);
    for (int i = 0; i < 4; i++) pulse(hmask, 65, 135);
    pulse(vmask, vlen, 100);
    for (int i = 0; i < 3; i++) pulse(hmask, 65, 135);
  endtask

  initial begin
    tick(5);
    // R8: reset state
    check(vd_out, 1'b0, "R8", "reset vd");
    check(hd_out, 1'b0, "R8", "reset hd");
    check(ext_sync, 1'b0, "R8", "reset ext");
    check(vint_out, 1'b0, "R8", "reset vint");
    rst = 1'b0;
    tick(3);
    // R3: video only, HD kept then blanked (R5)
    frame(3'b100, 3'b100, 500);
    keep = 1'b0;
    frame(3'b100, 3'b100, 500);
    keep = 1'b1;
    // R3: vertical separate alone still uses video
    vsp = 1'b1;
    tick(4);
    frame(3'b101, 3'b101, 500);
    vsp = 1'b0;
    tick(4);
    vd_win = 0;
    // R4: threshold boundary on composite
    csp = 1'b1;
    tick(4);
    pulse(3'b010, TH - 1, 300);
    count_check(0, "R4 short run");
    pulse(3'b010, TH, 300);
    count_check(1, "R4 exact run");
    pulse(3'b010, 500, 300);
    count_check(101, "R4 long run");
    // R2: composite frames, blanked HD
    keep = 1'b0;
    frame(3'b010, 3'b010, 500);
    keep = 1'b1;
    vd_win = 0;
    // R7: vertical separate appears but stays idle: composite keeps driving
    vsp = 1'b1;
    tick(4);
    pulse(3'b010, 500, 300);
    count_check(101, "R7 pending switch");
    pulse(3'b001, 50, 300);
    count_check(50, "R7 switch on rise");
    // R1: separate sources, HD kept and blanked
    frame(3'b010, 3'b011, 60);
    keep = 1'b0;
    frame(3'b010, 3'b011, 60);
    keep = 1'b1;
    // R6: drop all presence, back to video after its next vertical pulse
    vsp = 1'b0; csp = 1'b0;
    tick(4);
    frame(3'b100, 3'b100, 450);
    tick(10);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    finished = 1;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule